// File: doc/BRIEF.md
# Sequential Signed/Unsigned Multiplier with Overflow and Carry Flags

This block multiplies an accumulator operand by a source operand, either as unsigned integers or as two's complement integers, at one of two operand sizes. The narrow size multiplies the low byte of the accumulator by the low byte of the source and gives a 16-bit product. The wide size multiplies the full 16-bit accumulator by the 16-bit source and gives a 32-bit product. The product comes out as an upper half and a lower half, each as wide as the selected operand size.

The block also reports two flags, overflow and carry, which always carry the same value. For an unsigned multiply they mark a nonzero upper half. For a signed multiply they mark an upper half that is not the sign extension of the lower half. Any other arithmetic status is left undefined, and the block does not produce it.

The block loads its operands when a start pulse arrives while it is idle. It then runs one shift-and-add step per operand bit on the operand magnitudes. A final cycle restores the sign and evaluates the flags. A one-cycle done pulse marks the result, and the result stays on the outputs until the next operation completes.

Top module: `mulflag_unit`

## Requirements
- R1: In narrow mode (op_wide=0) only bits 7:0 of acc_in and src_in are used. The product's upper byte appears on res_hi[7:0] and its lower byte on res_lo[7:0]. Bits 15:8 of res_hi and res_lo are zero.
- R2: In wide mode (op_wide=1) the 32-bit product appears with bits 31:16 on res_hi and bits 15:0 on res_lo.
- R3: With op_signed=0 both operands are unsigned. For example, 0x80 times 0xFE in narrow mode gives upper 0x7F and lower 0x00.
- R4: With op_signed=1 both operands are two's complement. For example, 0x80 times 0xFE in narrow mode gives upper 0x01 and lower 0x00, and 0x8000 times 0x8000 in wide mode gives 0x4000_0000.
- R5: After an unsigned multiply, of_flag and cf_flag are both 1 when the upper half is nonzero, and both 0 otherwise.
- R6: After a signed multiply, of_flag and cf_flag are both 0 when every bit of the upper half equals the top bit of the lower half (bit 7 in narrow mode, bit 15 in wide mode), and both 1 otherwise.
- R7: done is high for exactly one cycle. It rises N+1 rising edges after the edge that accepts start, where N is 8 in narrow mode and 16 in wide mode. busy is high from the accepting edge until the edge that raises done.
- R8: A start pulse while busy is high has no effect. The running operation keeps its operands, its result and its timing, and no extra done pulse appears.
- R9: Operands and mode are captured on the accepting edge. The result outputs and flags change only on the edge that raises done, and otherwise hold whatever acc_in and src_in do.
- R10: While rst_n is low, and after reset until the first done, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation; accepted only when busy is low |
| op_signed | input | 1 | 1: two's complement multiply, 0: unsigned |
| op_wide | input | 1 | 1: 16-bit operands, 0: 8-bit operands |
| acc_in | input | 16 | Accumulator operand |
| src_in | input | 16 | Source operand |
| res_hi | output | 16 | Upper half of product (zero-extended in narrow mode) |
| res_lo | output | 16 | Lower half of product (zero-extended in narrow mode) |
| of_flag | output | 1 | Overflow flag |
| cf_flag | output | 1 | Carry flag, equal to of_flag |
| done | output | 1 | One-cycle result strobe |
| busy | output | 1 | Operation in progress |

## Verification
The bench builds the block with its default parameters, an 8-bit narrow size and a 16-bit wide size. With these values the full operand range of both sizes is in reach. That includes the most negative values in both sizes, whose magnitude needs the top bit, and the pairs whose flags flip exactly at the sign-extension boundary. The short 9- and 17-cycle runs let the bench drive a stray start into both a narrow run and a wide run. They also let it run dozens of random products under a scoreboard that checks the latency of every operation.

// File: rtl/mulflag_pkg.sv
package mulflag_pkg;
   typedef enum logic [1:0] {
      MF_IDLE  = 2'd0,
      MF_RUN   = 2'd1,
      MF_FINAL = 2'd2
   } mf_state_e;
endpackage

// File: rtl/mf_opnd_cond.sv
// Turns a raw operand into its magnitude and sign, for the selected size and signedness.
module mf_opnd_cond #(
   parameter int NARROW_W = 8,
   parameter int WIDE_W   = 16
) (
   input  logic [WIDE_W-1:0] raw,
   input  logic              is_signed,
   input  logic              is_wide,
   output logic [WIDE_W-1:0] mag,
   output logic              neg
);
   localparam int PAD_W = WIDE_W - NARROW_W;

   logic [WIDE_W-1:0] ext;
   logic              top_bit;

   always_comb begin
      top_bit = is_wide ? raw[WIDE_W-1] : raw[NARROW_W-1];
      neg     = is_signed & top_bit;
      if (is_wide)
         ext = raw;
      else
         ext = {{PAD_W{is_signed & raw[NARROW_W-1]}}, raw[NARROW_W-1:0]};
      mag = neg ? (~ext + WIDE_W'(1)) : ext;
   end
endmodule

// File: rtl/mf_shift_add_core.sv
// Unsigned shift-and-add datapath: one partial product per step.
module mf_shift_add_core #(
   parameter int WIDE_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic                step,
   input  logic [WIDE_W-1:0]   mcand,
   input  logic [WIDE_W-1:0]   mplier,
   output logic [2*WIDE_W-1:0] product
);
   localparam int PW = 2 * WIDE_W;

   logic [PW-1:0]     acc_q;
   logic [PW-1:0]     mc_q;
   logic [WIDE_W-1:0] mp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         mc_q  <= '0;
         mp_q  <= '0;
      end else if (load) begin
         acc_q <= '0;
         mc_q  <= PW'(mcand);
         mp_q  <= mplier;
      end else if (step) begin
         if (mp_q[0])
            acc_q <= acc_q + mc_q;
         mc_q <= mc_q << 1;
         mp_q <= mp_q >> 1;
      end
   end

   assign product = acc_q;
endmodule

// File: rtl/mf_flag_eval.sv
// Restores the sign, packs the halves for the selected size and evaluates the flag.
module mf_flag_eval #(
   parameter int NARROW_W = 8,
   parameter int WIDE_W   = 16
) (
   input  logic [2*WIDE_W-1:0] mag_prod,
   input  logic                negate,
   input  logic                is_signed,
   input  logic                is_wide,
   output logic [WIDE_W-1:0]   hi,
   output logic [WIDE_W-1:0]   lo,
   output logic                flag
);
   localparam int PW = 2 * WIDE_W;

   logic [PW-1:0]       res;
   logic [NARROW_W-1:0] n_hi, n_lo;
   logic [WIDE_W-1:0]   w_hi, w_lo;

   always_comb begin
      res  = negate ? (~mag_prod + PW'(1)) : mag_prod;
      n_hi = res[2*NARROW_W-1:NARROW_W];
      n_lo = res[NARROW_W-1:0];
      w_hi = res[PW-1:WIDE_W];
      w_lo = res[WIDE_W-1:0];
      if (is_wide) begin
         hi   = w_hi;
         lo   = w_lo;
         flag = is_signed ? (w_hi != {WIDE_W{w_lo[WIDE_W-1]}}) : (w_hi != '0);
      end else begin
         hi   = WIDE_W'(n_hi);
         lo   = WIDE_W'(n_lo);
         flag = is_signed ? (n_hi != {NARROW_W{n_lo[NARROW_W-1]}}) : (n_hi != '0);
      end
   end
endmodule

// File: rtl/mulflag_unit.sv
module mulflag_unit
   import mulflag_pkg::*;
#(
   parameter int NARROW_W = 8,
   parameter int WIDE_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              op_signed,
   input  logic              op_wide,
   input  logic [WIDE_W-1:0] acc_in,
   input  logic [WIDE_W-1:0] src_in,
   output logic [WIDE_W-1:0] res_hi,
   output logic [WIDE_W-1:0] res_lo,
   output logic              of_flag,
   output logic              cf_flag,
   output logic              done,
   output logic              busy
);
   localparam int PW    = 2 * WIDE_W;
   localparam int CNT_W = $clog2(WIDE_W + 1);

   if (NARROW_W < 2 || WIDE_W <= NARROW_W) begin : g_bad_widths
      $error("mulflag_unit: need 2 <= NARROW_W < WIDE_W");
   end

   mf_state_e         state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              signed_q, wide_q, neg_q;
   logic              accept;

   logic [WIDE_W-1:0] raw   [2];
   logic [WIDE_W-1:0] mag   [2];
   logic              sgn   [2];

   assign raw[0] = acc_in;
   assign raw[1] = src_in;

   for (genvar g = 0; g < 2; g++) begin : g_cond
      mf_opnd_cond #(.NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_cond (
         .raw       (raw[g]),
         .is_signed (op_signed),
         .is_wide   (op_wide),
         .mag       (mag[g]),
         .neg       (sgn[g])
      );
   end

   assign busy   = (state_q != MF_IDLE);
   assign accept = start && !busy;

   logic [PW-1:0] mag_prod;

   mf_shift_add_core #(.WIDE_W(WIDE_W)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (accept),
      .step    (state_q == MF_RUN),
      .mcand   (mag[0]),
      .mplier  (mag[1]),
      .product (mag_prod)
   );

   logic [WIDE_W-1:0] fin_hi, fin_lo;
   logic              fin_flag;

   mf_flag_eval #(.NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_flags (
      .mag_prod  (mag_prod),
      .negate    (neg_q),
      .is_signed (signed_q),
      .is_wide   (wide_q),
      .hi        (fin_hi),
      .lo        (fin_lo),
      .flag      (fin_flag)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= MF_IDLE;
         cnt_q    <= '0;
         signed_q <= 1'b0;
         wide_q   <= 1'b0;
         neg_q    <= 1'b0;
         res_hi   <= '0;
         res_lo   <= '0;
         of_flag  <= 1'b0;
         cf_flag  <= 1'b0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state_q)
            MF_IDLE: if (start) begin
               signed_q <= op_signed;
               wide_q   <= op_wide;
               neg_q    <= sgn[0] ^ sgn[1];
               cnt_q    <= op_wide ? CNT_W'(WIDE_W) : CNT_W'(NARROW_W);
               state_q  <= MF_RUN;
            end
            MF_RUN: begin
               cnt_q <= cnt_q - CNT_W'(1);
               if (cnt_q == CNT_W'(1))
                  state_q <= MF_FINAL;
            end
            MF_FINAL: begin
               res_hi  <= fin_hi;
               res_lo  <= fin_lo;
               of_flag <= fin_flag;
               cf_flag <= fin_flag;
               done    <= 1'b1;
               state_q <= MF_IDLE;
            end
            default: state_q <= MF_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/mulflag_unit_chk.sv
module mulflag_unit_chk #(
   parameter int NARROW_W = 8,
   parameter int WIDE_W   = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              op_signed,
   input logic              op_wide,
   input logic [WIDE_W-1:0] res_hi,
   input logic [WIDE_W-1:0] res_lo,
   input logic              of_flag,
   input logic              done,
   input logic              busy
);
   localparam int LW = $clog2(WIDE_W + 2) + 1;

   logic [LW-1:0] lat_q;
   logic          sgn_q, wid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_q <= '0;
         sgn_q <= 1'b0;
         wid_q <= 1'b0;
      end else if (start && !busy) begin
         lat_q <= '0;
         sgn_q <= op_signed;
         wid_q <= op_wide;
      end else if (busy) begin
         lat_q <= lat_q + LW'(1);
      end
   end

   p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> lat_q == (wid_q ? LW'(WIDE_W + 1) : LW'(NARROW_W + 1)));

   p_idle_at_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   p_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(res_hi) && $stable(res_lo) && $stable(of_flag)));

   p_narrow_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !wid_q) |-> (res_hi[WIDE_W-1:NARROW_W] == '0 && res_lo[WIDE_W-1:NARROW_W] == '0));

   p_uflag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !sgn_q) |-> (of_flag == (res_hi != '0)));

   p_sflag_wide_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && sgn_q && wid_q) |-> (of_flag == (res_hi != {WIDE_W{res_lo[WIDE_W-1]}})));

   p_sflag_narrow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && sgn_q && !wid_q) |->
         (of_flag == (res_hi[NARROW_W-1:0] != {NARROW_W{res_lo[NARROW_W-1]}})));
endmodule

bind mulflag_unit mulflag_unit_chk #(.NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .op_signed (op_signed),
   .op_wide   (op_wide),
   .res_hi    (res_hi),
   .res_lo    (res_lo),
   .of_flag   (of_flag),
   .done      (done),
   .busy      (busy)
);

// File: tb/mulflag_unit_bench.sv
module mulflag_unit_bench;
   localparam int NW = 8;
   localparam int WW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          op_signed = 1'b0;
   logic          op_wide = 1'b0;
   logic [WW-1:0] acc_in = '0;
   logic [WW-1:0] src_in = '0;
   logic [WW-1:0] res_hi, res_lo;
   logic          of_flag, cf_flag, done, busy;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit prev_done = 1'b0;

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   mulflag_unit #(.NARROW_W(NW), .WIDE_W(WW)) u_mulflag_unit (
      .clk(clk), .rst_n(rst_n), .start(start), .op_signed(op_signed), .op_wide(op_wide),
      .acc_in(acc_in), .src_in(src_in), .res_hi(res_hi), .res_lo(res_lo),
      .of_flag(of_flag), .cf_flag(cf_flag), .done(done), .busy(busy));

   typedef struct {
      logic [WW-1:0] hi;
      logic [WW-1:0] lo;
      logic          flag;
      int            acc_cyc;
      int            lat;
      string         req;
   } item_t;

   item_t sb[$];

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic item_t model(input logic [WW-1:0] a, input logic [WW-1:0] b,
                                   input logic s, input logic w, input string req);
      item_t it;
      longint ea, eb, p;
      logic [31:0] p32;
      if (w) begin
         ea = s ? longint'($signed(a)) : longint'(a);
         eb = s ? longint'($signed(b)) : longint'(b);
      end else begin
         ea = s ? longint'($signed(a[7:0])) : longint'(a[7:0]);
         eb = s ? longint'($signed(b[7:0])) : longint'(b[7:0]);
      end
      p   = ea * eb;
      p32 = p[31:0];
      if (w) begin
         it.hi   = p32[31:16];
         it.lo   = p32[15:0];
         it.flag = s ? (p32[31:16] != {16{p32[15]}}) : (p32[31:16] != 16'h0);
         it.lat  = WW + 1;
      end else begin
         it.hi   = {8'h00, p32[15:8]};
         it.lo   = {8'h00, p32[7:0]};
         it.flag = s ? (p32[15:8] != {8{p32[7]}}) : (p32[15:8] != 8'h0);
         it.lat  = NW + 1;
      end
      it.req = req;
      return it;
   endfunction

   // Driver: launches one operation and pushes its expected result.
   task automatic launch(input logic [WW-1:0] a, input logic [WW-1:0] b,
                         input logic s, input logic w, input string req);
      item_t it;
      @(negedge clk);
      while (busy) @(negedge clk);
      it = model(a, b, s, w, req);
      acc_in = a; src_in = b; op_signed = s; op_wide = w; start = 1'b1;
      @(posedge clk);
      #1;
      it.acc_cyc = cyc;
      sb.push_back(it);
      @(negedge clk);
      start = 1'b0;
      acc_in = ~a; src_in = ~b; op_signed = ~s;
   endtask

   task automatic drain();
      while (sb.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   // Monitor: pops the scoreboard at each done.
   always @(negedge clk) begin
      if (rst_n) begin
         if (done) begin
            if (sb.size() == 0) begin
               chk(1'b0, "R8 unexpected done", 1, 0);
            end else begin
               item_t e;
               e = sb.pop_front();
               chk(res_hi == e.hi, {e.req, " upper half"}, res_hi, e.hi);
               chk(res_lo == e.lo, {e.req, " lower half"}, res_lo, e.lo);
               chk(of_flag == e.flag, {e.req, " of_flag"}, of_flag, e.flag);
               chk(cf_flag == e.flag, {e.req, " cf_flag"}, cf_flag, e.flag);
               chk((cyc - e.acc_cyc) == e.lat, "R7 latency", cyc - e.acc_cyc, e.lat);
               chk(!busy, "R7 busy low at done", busy, 0);
            end
         end
         if (done && prev_done) chk(1'b0, "R7 done longer than one cycle", 2, 1);
         prev_done = done;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL R7 watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [WW-1:0] h_hi, h_lo;
      logic          h_of;
      int            seen;

      repeat (4) @(negedge clk);
      // R10: outputs quiet in and after reset
      chk(res_hi == 0 && res_lo == 0 && !of_flag && !cf_flag && !done && !busy,
          "R10 during reset", {res_hi, res_lo}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(res_hi == 0 && res_lo == 0 && !of_flag && !cf_flag && !done && !busy,
          "R10 after reset", {res_hi, res_lo}, 0);

      // R3 R5 R4 R6 R1: the 0x80 x 0xFE corner, with junk in the unused upper bytes
      launch(16'hAB80, 16'h77FE, 1'b0, 1'b0, "R3/R5/R1 unsigned 80xFE");
      launch(16'h5580, 16'hC3FE, 1'b1, 1'b0, "R4/R6/R1 signed 80xFE");
      launch(16'h0003, 16'h0005, 1'b0, 1'b0, "R3/R5 unsigned small no flag");
      launch(16'h00FD, 16'h0005, 1'b1, 1'b0, "R4/R6 signed -3x5 no flag");
      launch(16'h0080, 16'h0080, 1'b1, 1'b0, "R4/R6 signed -128x-128");
      launch(16'h0040, 16'h0002, 1'b1, 1'b0, "R6 signed 64x2 boundary");
      launch(16'h00FF, 16'h00FF, 1'b0, 1'b0, "R3/R5 unsigned FFxFF");
      // R2: wide products
      launch(16'h1234, 16'h5678, 1'b0, 1'b1, "R2/R3/R5 unsigned wide");
      launch(16'hFFFF, 16'hFFFF, 1'b0, 1'b1, "R2/R3/R5 unsigned FFFFxFFFF");
      launch(16'h8000, 16'h8000, 1'b1, 1'b1, "R2/R4/R6 signed 8000x8000");
      launch(16'hFFFF, 16'h0001, 1'b1, 1'b1, "R2/R4/R6 signed -1x1 no flag");
      launch(16'h0100, 16'h0080, 1'b1, 1'b1, "R2/R6 signed 256x128 boundary");
      launch(16'h0000, 16'h8000, 1'b1, 1'b1, "R2/R4 signed zero");
      drain();

      // R8: stray starts while busy, narrow then wide
      for (int m = 0; m < 2; m++) begin
         launch(16'h00C3, 16'h0011, 1'b1, m[0], "R8 op with intrusion");
         repeat (3) @(negedge clk);
         acc_in = 16'h7F7F; src_in = 16'h7F7F; op_signed = 1'b0; op_wide = ~m[0]; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         drain();
         seen = 0;
         for (int k = 0; k < WW + 4; k++) begin
            @(negedge clk);
            if (done || busy) seen++;
         end
         chk(seen == 0, "R8 no second operation", seen, 0);
      end

      // R9: results hold while inputs move and no start arrives
      launch(16'h00F0, 16'h000F, 1'b0, 1'b0, "R9 op before hold");
      drain();
      h_hi = res_hi; h_lo = res_lo; h_of = of_flag;
      for (int k = 0; k < 10; k++) begin
         @(negedge clk);
         acc_in = acc_in + 16'h1357; src_in = src_in ^ 16'h0F0F;
         op_signed = ~op_signed; op_wide = ~op_wide;
      end
      chk(res_hi == h_hi && res_lo == h_lo && of_flag == h_of, "R9 hold",
          {res_hi, res_lo}, {h_hi, h_lo});

      // R9: operands changed right after acceptance do not disturb the run
      launch(16'h1111, 16'h0009, 1'b1, 1'b1, "R9 captured operands");

      // Random mix of sizes and signedness
      for (int k = 0; k < 60; k++) begin
         launch(WW'($urandom), WW'($urandom), 1'($urandom), 1'($urandom), "R1/R2/R5/R6 random");
      end
      drain();
      chk(sb.size() == 0, "R8 scoreboard empty", sb.size(), 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule